// File: doc/BRIEF.md
# Trap Vector Register with Target Generation

This block holds the 64-bit trap-vector setting for a virtualized supervisor privilege level and turns it into a jump address whenever a trap is presented. Software reaches it through a CSR-style port: an address compare, a write strobe, write data and read data. Every write is legalized one field at a time. The upper field holds a word-aligned base address. The two low bits select how interrupts are dispatched.

A trap request has two parts: a flag that marks it as an asynchronous interrupt or a synchronous exception, and a 6-bit cause code. The block returns the target address combinationally. In direct dispatch every trap lands on the base. In vectored dispatch an interrupt lands at the base plus four times its cause, and an exception still lands on the base. A write rejects a base address that is not in canonical 49-bit form, which keeps the vector inside the valid virtual address space.

Top module: `trap_vector_csr`

## Requirements
- R1: After reset the stored register is zero, so a read at address 0x205 returns 0 and every trap target is 0.
- R2: When `csr_addr` equals 0x205, `csr_rdata` returns the stored value, with base bits 63:2 and dispatch mode bits 1:0. At any other address `csr_rdata` is 0.
- R3: The register changes only on a clock edge where `csr_we` is high and `csr_addr` equals 0x205. A write strobe at any other address leaves the stored value unchanged.
- R4: A written mode of 0 (direct) or 1 (vectored) is stored. A written mode of 2 or 3 is dropped and the previous mode is kept.
- R5: The base is stored only when write data bits 63:49 all equal bit 48. Otherwise the previous base is kept. A canonical upper-half address such as 0xFFFF_8000_0000_0100 is accepted.
- R6: The base check and the mode check act independently within one write. An illegal mode does not stop a legal base from being stored, and an illegal base does not stop a legal mode from being stored.
- R7: In direct mode (mode 0), `trap_target` equals the base shifted left by 2 for both interrupts and exceptions, whatever the cause.
- R8: In vectored mode (mode 1), with `trap_async` high, `trap_target` equals (base << 2) + zero-extended `trap_cause` * 4, wrapping modulo 2^64.
- R9: In vectored mode, with `trap_async` low, `trap_target` equals base << 2 and ignores the cause.
- R10: A write becomes visible on the edge that ends its strobe cycle. A trap presented in the same cycle as a write uses the old register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data: base in bits 63:2, mode in bits 1:0 |
| csr_rdata | output | 64 | Read data; zero when the address does not match |
| trap_async | input | 1 | 1 = asynchronous interrupt, 0 = synchronous exception |
| trap_cause | input | 6 | Cause code of the trap |
| trap_target | output | 64 | Computed jump address |

## Verification
The hardest case to reach is a single write that carries one legal field and one illegal field, because the outcome is visible only in the read of the following cycle. The stimulus sends an illegal mode together with a fresh base, then a non-canonical base together with a legal mode, and reads the register back each time. Two further cases are driven directly. A near-top base with cause 63 forces the vectored sum to wrap past 2^64. A write issued together with a trap shows that the trap still sees the old register value.

// File: rtl/tvec_pkg.sv
`timescale 1ns/1ps
package tvec_pkg;
  typedef enum logic [1:0] {
    TV_DIRECT   = 2'd0,
    TV_VECTORED = 2'd1
  } tv_mode_e;
endpackage

// File: rtl/tvec_legalize.sv
`timescale 1ns/1ps
module tvec_legalize #(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 49
) (
  input  logic [XLEN-1:0]  wdata,
  output logic             base_ok,
  output logic             mode_ok,
  output logic [XLEN-3:0]  new_base,
  output tvec_pkg::tv_mode_e new_mode
);
  localparam int TOP_W = XLEN - VA_BITS + 1;

  logic [TOP_W-1:0] top_bits;

  always_comb begin
    top_bits = wdata[XLEN-1:VA_BITS-1];
    base_ok  = (&top_bits) | ~(|top_bits);
    mode_ok  = ~wdata[1];
    new_base = wdata[XLEN-1:2];
    new_mode = tvec_pkg::tv_mode_e'(wdata[1:0]);
  end
endmodule

// File: rtl/tvec_store.sv
`timescale 1ns/1ps
module tvec_store #(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               base_ok,
  input  logic               mode_ok,
  input  logic [XLEN-3:0]    new_base,
  input  tvec_pkg::tv_mode_e new_mode,
  output logic [XLEN-3:0]    base_q,
  output tvec_pkg::tv_mode_e mode_q
);
  logic               base_en;
  logic               mode_en;
  logic [XLEN-3:0]    base_d;
  tvec_pkg::tv_mode_e mode_d;

  always_comb begin
    base_en = wr_en & base_ok;
    mode_en = wr_en & mode_ok;
    base_d  = base_en ? new_base : base_q;
    mode_d  = mode_en ? new_mode : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= tvec_pkg::TV_DIRECT;
    end else begin
      base_q <= base_d;
      mode_q <= mode_d;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_q) && $stable(mode_q)));

  // R4
  bad_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_ok) |=> $stable(mode_q));

  // R5
  noncanon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !base_ok) |=> $stable(base_q));

  // R10
  mode_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_ok) |=> (mode_q == $past(new_mode)));
endmodule

// File: rtl/tvec_target.sv
`timescale 1ns/1ps
module tvec_target #(
  parameter int XLEN    = 64,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-3:0]    base_q,
  input  tvec_pkg::tv_mode_e mode_q,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_target
);
  localparam int PAD_W = XLEN - CAUSE_W - 2;

  logic [XLEN-1:0] base_addr;
  logic [XLEN-1:0] offset;
  logic            use_vec;

  always_comb begin
    base_addr   = {base_q, 2'b00};
    use_vec     = (mode_q == tvec_pkg::TV_VECTORED) & trap_async;
    offset      = use_vec ? {{PAD_W{1'b0}}, trap_cause, 2'b00} : '0;
    trap_target = base_addr + offset;
  end
endmodule

// File: rtl/trap_vector_csr.sv
`timescale 1ns/1ps
module trap_vector_csr #(
  parameter int          XLEN     = 64,
  parameter int          VA_BITS  = 49,
  parameter int          CAUSE_W  = 6,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] CSR_ADDR = 12'h205
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic               csr_we,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_target
);
  logic               hit;
  logic               wr_en;
  logic               base_ok;
  logic               mode_ok;
  logic [XLEN-3:0]    new_base;
  tvec_pkg::tv_mode_e new_mode;
  logic [XLEN-3:0]    base_q;
  tvec_pkg::tv_mode_e mode_q;

  always_comb begin
    hit       = (csr_addr == ADDR_W'(CSR_ADDR));
    wr_en     = hit & csr_we;
    csr_rdata = hit ? {base_q, mode_q} : '0;
  end

  tvec_legalize #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_legal (
    .wdata    (csr_wdata),
    .base_ok  (base_ok),
    .mode_ok  (mode_ok),
    .new_base (new_base),
    .new_mode (new_mode)
  );

  tvec_store #(.XLEN(XLEN)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .base_ok  (base_ok),
    .mode_ok  (mode_ok),
    .new_base (new_base),
    .new_mode (new_mode),
    .base_q   (base_q),
    .mode_q   (mode_q)
  );

  tvec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_target (
    .base_q      (base_q),
    .mode_q      (mode_q),
    .trap_async  (trap_async),
    .trap_cause  (trap_cause),
    .trap_target (trap_target)
  );

  // R2
  rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (csr_rdata == '0));

  // R7
  direct_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == tvec_pkg::TV_DIRECT) |-> (trap_target[XLEN-1:2] == base_q));

  // R9
  sync_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_async |-> (trap_target[XLEN-1:2] == base_q));

  // R8
  vec_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_target[1:0] == 2'b00);
endmodule

// File: tb/trap_vector_csr_bench.sv
`timescale 1ns/1ps
module trap_vector_csr_bench;
  logic        clk;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic        csr_we;
  logic [63:0] csr_wdata;
  logic [63:0] csr_rdata;
  logic        trap_async;
  logic [5:0]  trap_cause;
  logic [63:0] trap_target;

  int n_chk;
  int n_fail;

  logic [61:0] m_base;
  logic [1:0]  m_mode;

  string       q_req[$];
  logic [63:0] q_rd[$];
  logic [63:0] q_tg[$];

  trap_vector_csr u_trap_vector_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_we      (csr_we),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .trap_async  (trap_async),
    .trap_cause  (trap_cause),
    .trap_target (trap_target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] exp_target(logic async_i, logic [5:0] cause_i);
    logic [63:0] t;
    t = {m_base, 2'b00};
    if (m_mode == 2'd1 && async_i) t = t + {56'd0, cause_i, 2'b00};
    return t;
  endfunction

  task automatic step(input logic [11:0] addr, input logic we, input logic [63:0] wd,
                      input logic async_i, input logic [5:0] cause_i, input string req);
    logic top_ok;
    @(posedge clk);
    #1;
    csr_addr   = addr;
    csr_we     = we;
    csr_wdata  = wd;
    trap_async = async_i;
    trap_cause = cause_i;
    q_req.push_back(req);
    q_rd.push_back((addr == 12'h205) ? {m_base, m_mode} : 64'd0);
    q_tg.push_back(exp_target(async_i, cause_i));
    if (we && addr == 12'h205) begin
      top_ok = (wd[63:48] == 16'h0000) || (wd[63:48] == 16'hFFFF);
      if (top_ok) m_base = wd[63:2];
      if (wd[1:0] == 2'd0 || wd[1:0] == 2'd1) m_mode = wd[1:0];
    end
  endtask

  always @(negedge clk) begin
    while (q_req.size() > 0) begin
      string       r;
      logic [63:0] er;
      logic [63:0] et;
      r  = q_req.pop_front();
      er = q_rd.pop_front();
      et = q_tg.pop_front();
      n_chk++;
      if (csr_rdata !== er) begin
        n_fail++;
        $display("FAIL %s rdata actual=%h expected=%h", r, csr_rdata, er);
      end
      n_chk++;
      if (trap_target !== et) begin
        n_fail++;
        $display("FAIL %s target actual=%h expected=%h", r, trap_target, et);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_base = '0; m_mode = '0;
    rst_n = 1'b0;
    csr_addr = 12'h205; csr_we = 1'b0; csr_wdata = '0;
    trap_async = 1'b1; trap_cause = 6'd5;
    #23;
    // R1: reset state while reset is held
    n_chk++;
    if (csr_rdata !== 64'd0 || trap_target !== 64'd0) begin
      n_fail++;
      $display("FAIL R1 during reset actual=%h/%h expected=0/0", csr_rdata, trap_target);
    end
    rst_n = 1'b1;
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd5, "R1");
    // R10: write with same-cycle trap sees old value
    step(12'h205, 1'b1, 64'h0000_0000_8000_1001, 1'b1, 6'd9, "R10");
    // R2 / R8: read back and vectored interrupt
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd3, "R8");
    // R9: vectored exception ignores the cause
    step(12'h205, 1'b0, 64'd0, 1'b0, 6'd3, "R9");
    // R3: write strobe at another address
    step(12'h105, 1'b1, 64'd0, 1'b0, 6'd0, "R3");
    step(12'h205, 1'b0, 64'd0, 1'b0, 6'd0, "R3");
    // R4/R6: illegal mode, legal base
    step(12'h205, 1'b1, 64'h0000_0000_0000_4002, 1'b0, 6'd0, "R6");
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd2, "R4");
    // R5/R6: non-canonical base, legal mode
    step(12'h205, 1'b1, 64'h0001_0000_0000_0000, 1'b0, 6'd0, "R6");
    // R7: direct mode ignores cause for interrupts
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd7, "R7");
    step(12'h205, 1'b0, 64'd0, 1'b0, 6'd7, "R7");
    // R5: canonical upper-half base accepted
    step(12'h205, 1'b1, 64'hFFFF_8000_0000_0101, 1'b1, 6'd1, "R10");
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd63, "R5");
    // R8: wrap modulo 2^64
    step(12'h205, 1'b1, 64'hFFFF_FFFF_FFFF_FFF1, 1'b0, 6'd0, "R8");
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd63, "R8");
    // R4: mode 3 dropped
    step(12'h205, 1'b1, 64'hFFFF_FFFF_FFFF_FFF3, 1'b0, 6'd0, "R4");
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd1, "R4");
    // R5: top bit set, bit 48 clear is non-canonical
    step(12'h205, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 6'd0, "R5");
    step(12'h205, 1'b0, 64'd0, 1'b1, 6'd4, "R5");
    // R2: other address reads zero
    step(12'h300, 1'b0, 64'd0, 1'b1, 6'd4, "R2");
    @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule